// File: doc/BRIEF.md
# Bit-Test Conditional Branch Unit

This unit sits in the decode/execute stage of a 64-bit in-order pipeline. It picks out a family of four conditional branch encodings that examine one bit of a general-purpose register. For each such branch it decides whether the branch is taken and computes the destination address. The register number is returned combinationally so that the register file can supply the operand value in the same cycle. Every result is registered.

A six-bit index selects the tested bit. The low five bits of the index come from the field that other encodings use as a second register number. Its top bit is a primary-opcode bit, so two of the four encodings reach register bits 32 to 63. Another opcode bit chooses whether the branch fires on a one or on a zero. A branch that shows up while the delay-slot flag is set is refused: the unit raises a reserved-instruction exception instead of a taken result.

The unit takes one instruction per cycle under `valid_i` and has no ready signal. It never applies back-pressure, and the consumer must accept each registered result in the cycle after it appears. When `valid_i` is low the registered outputs hold their values.

Top module: `bitbr_unit`

## Requirements
- R1: An instruction is recognised when bits 31:30 equal 2'b11 and bits 27:26 equal 2'b10, which gives primary opcodes 6'b110010, 6'b110110, 6'b111010 and 6'b111110. Any other word registers `match_o`, `taken_o`, `ri_exc_o` and `next_slot_o` as 0 and `target_o` as 0.
- R2: Instruction bit 29 selects the test sense. When it is 1 the branch is taken if the tested bit is 1. When it is 0 the branch is taken if the tested bit is 0.
- R3: The tested bit index is {instruction bit 28, instruction bits 20:16}, a value from 0 to 63 into `rs_val_i`.
- R4: `src_sel_o` equals instruction bits 25:21 combinationally, in the same cycle.
- R5: For a recognised branch, `target_o` = `pc_i` + 4 + (sign-extended bits 15:0) × 4, computed modulo 2^64.
- R6: A recognised branch with `in_slot_i` = 1 registers `ri_exc_o` = 1, `match_o` = 1, `taken_o` = 0 and `next_slot_o` = 0.
- R7: A recognised branch with `in_slot_i` = 0 registers `next_slot_o` = 1 and `ri_exc_o` = 0, whether or not it is taken.
- R8: Registered outputs change only on a rising edge with `valid_i` = 1, and hold while `valid_i` = 0.
- R9: A synchronous active-high `rst` clears every registered output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction inputs are valid this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| rs_val_i | input | 64 | Value of the source register selected by `src_sel_o` |
| in_slot_i | input | 1 | Instruction occupies a delay slot |
| src_sel_o | output | 5 | Source register number (combinational) |
| match_o | output | 1 | Instruction was a bit-test branch |
| taken_o | output | 1 | Branch is taken |
| target_o | output | 64 | Branch destination address |
| ri_exc_o | output | 1 | Reserved-instruction exception (branch in delay slot) |
| next_slot_o | output | 1 | The following instruction is a delay slot |

## Verification
The bench builds the unit with its default width of 64, so the top index bit taken from bit 28 can reach every upper register position. It sweeps all 64 indices with both senses, and for each one it sets the tested bit alone and then clears it alone, which separates a wrong index from a wrong polarity. It also covers every 6-bit primary opcode for rejection, displacements at both sign extremes, an address that wraps, the branch-in-slot exception, and holding while `valid_i` is low.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
  localparam int INSN_W    = 32;
  localparam int SRC_W     = 5;
  localparam int DISP_W    = 16;
  localparam int BIT_IDX_W = 6;

  // fixed and free bit positions of the branch family
  localparam logic [1:0] TOP_PAT = 2'b11;  // bits 31:30
  localparam logic [1:0] MID_PAT = 2'b10;  // bits 27:26

  typedef struct packed {
    logic                  hit;
    logic                  want_one;
    logic [BIT_IDX_W-1:0]  idx;
    logic [SRC_W-1:0]      src;
    logic [DISP_W-1:0]     disp;
  } bitbr_fields_t;
endpackage

// File: rtl/bitbr_decode.sv
module bitbr_decode
  import bitbr_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output bitbr_fields_t     fld
);
  always_comb begin
    fld.hit      = (insn[31:30] == TOP_PAT) && (insn[27:26] == MID_PAT);
    fld.want_one = insn[29];
    fld.idx      = {insn[28], insn[20:16]};
    fld.src      = insn[25:21];
    fld.disp     = insn[15:0];
  end
endmodule

// File: rtl/bitbr_bittest.sv
module bitbr_bittest
  import bitbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]      val,
  input  logic [BIT_IDX_W-1:0] idx,
  input  logic                 want_one,
  output logic                 cond
);
  localparam int SPAN = 1 << BIT_IDX_W;

  logic picked;

  generate
    if (XLEN >= SPAN) begin : g_full
      assign picked = val[idx];
    end else begin : g_narrow
      // positions beyond the register width read as zero
      logic [SPAN-1:0] widened;
      assign widened = {{(SPAN-XLEN){1'b0}}, val};
      assign picked  = widened[idx];
    end
  endgenerate

  assign cond = want_one ? picked : ~picked;
endmodule

// File: rtl/bitbr_target.sv
module bitbr_target
  import bitbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   target
);
  localparam int EXT_W = XLEN - DISP_W - 2;

  logic [XLEN-1:0] byte_off;

  assign byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign target   = pc + XLEN'(4) + byte_off;
endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
  import bitbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic              in_slot_i,
  output logic [4:0]        src_sel_o,
  output logic              match_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o,
  output logic              ri_exc_o,
  output logic              next_slot_o
);
  bitbr_fields_t   fld;
  logic            cond;
  logic [XLEN-1:0] tgt;

  bitbr_decode u_dec (
    .insn (insn_i),
    .fld  (fld)
  );

  bitbr_bittest #(.XLEN(XLEN)) u_test (
    .val      (rs_val_i),
    .idx      (fld.idx),
    .want_one (fld.want_one),
    .cond     (cond)
  );

  bitbr_target #(.XLEN(XLEN)) u_tgt (
    .pc     (pc_i),
    .disp   (fld.disp),
    .target (tgt)
  );

  assign src_sel_o = fld.src;

  logic refuse, go;
  assign refuse = fld.hit & in_slot_i;
  assign go     = fld.hit & ~in_slot_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o     <= 1'b0;
      taken_o     <= 1'b0;
      target_o    <= '0;
      ri_exc_o    <= 1'b0;
      next_slot_o <= 1'b0;
    end else if (valid_i) begin
      match_o     <= fld.hit;
      taken_o     <= go & cond;
      target_o    <= fld.hit ? tgt : '0;
      ri_exc_o    <= refuse;
      next_slot_o <= go;
    end
  end

  // R6
  exc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ri_exc_o |-> (!taken_o && !next_slot_o && match_o));

  // R7
  slot_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o || next_slot_o) |-> (match_o && !ri_exc_o));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(match_o) && $stable(taken_o) && $stable(target_o)
                  && $stable(ri_exc_o) && $stable(next_slot_o)));

  // R1
  foreign_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !fld.hit) |=> (!match_o && !taken_o && !ri_exc_o
                               && !next_slot_o && target_o == '0));

  // R6
  slot_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && fld.hit && in_slot_i) |=> ri_exc_o);
endmodule

// File: tb/bitbr_unit_bench.sv
module bitbr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [31:0] insn_i;
  logic [63:0] pc_i;
  logic [63:0] rs_val_i;
  logic        in_slot_i;
  logic [4:0]  src_sel_o;
  logic        match_o, taken_o, ri_exc_o, next_slot_o;
  logic [63:0] target_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic        m_match, m_taken, m_exc, m_slot;
  logic [63:0] m_target;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitbr_unit u_bitbr_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .pc_i(pc_i),
    .rs_val_i(rs_val_i), .in_slot_i(in_slot_i), .src_sel_o(src_sel_o),
    .match_o(match_o), .taken_o(taken_o), .target_o(target_o),
    .ri_exc_o(ri_exc_o), .next_slot_o(next_slot_o)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic one, input int idx, input logic [4:0] rsn,
                                     input logic [15:0] disp);
    logic [5:0] i6;
    i6 = 6'(idx);
    return {2'b11, one, i6[5], 2'b10, rsn, i6[4:0], disp};
  endfunction

  task automatic model(input logic r, input logic v, input logic [31:0] w,
                       input logic [63:0] pc, input logic [63:0] rs, input logic sl);
    logic [5:0] op;
    bit hit;
    int idx;
    bit b;
    longint disp;
    op = w[31:26];
    hit = (op == 6'b110010) || (op == 6'b110110) || (op == 6'b111010) || (op == 6'b111110);
    if (r) begin
      m_match = 0; m_taken = 0; m_exc = 0; m_slot = 0; m_target = 0;
    end else if (v) begin
      idx = (w[28] ? 32 : 0) + int'(w[20:16]);
      b = ((rs >> idx) & 64'd1) != 0;
      disp = longint'($signed(w[15:0]));
      m_match  = hit;
      m_exc    = hit && sl;
      m_slot   = hit && !sl;
      m_taken  = hit && !sl && (b == w[29]);
      m_target = hit ? (pc + 64'd4 + 64'(disp * 4)) : 64'd0;
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [31:0] w,
                      input logic [63:0] pc, input logic [63:0] rs, input logic sl,
                      input string tag);
    @(negedge clk);
    rst = r; valid_i = v; insn_i = w; pc_i = pc; rs_val_i = rs; in_slot_i = sl;
    #1;
    chk({tag, " R4 src_sel"}, 64'(src_sel_o), 64'(w[25:21]));
    @(posedge clk);
    model(r, v, w, pc, rs, sl);
    #1;
    chk({tag, " R1 match"},      64'(match_o),     64'(m_match));
    chk({tag, " R2/R3 taken"},   64'(taken_o),     64'(m_taken));
    chk({tag, " R5 target"},     target_o,         m_target);
    chk({tag, " R6 exception"},  64'(ri_exc_o),    64'(m_exc));
    chk({tag, " R7 next_slot"},  64'(next_slot_o), 64'(m_slot));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual %0d cycles expected fewer", WATCHDOG_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; valid_i = 0; insn_i = 0; pc_i = 0; rs_val_i = 0; in_slot_i = 0;
    m_match = 0; m_taken = 0; m_exc = 0; m_slot = 0; m_target = 0;
    // R9 reset state
    step(1, 0, 0, 0, 0, 0, "R9 reset");
    step(1, 1, mk(1, 3, 5'd1, 16'h0010), 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R9 reset-valid");

    // R2 R3 every position, both senses, bit set alone and cleared alone
    for (int i = 0; i < 64; i++) begin
      for (int s = 0; s < 2; s++) begin
        step(0, 1, mk(s[0], i, 5'(i), 16'h0004), 64'h4000 + 64'(i * 8),
             64'd1 << i, 0, "R3 bit-set");
        step(0, 1, mk(s[0], i, 5'(i + 7), 16'hFFFC), 64'h8000,
             ~(64'd1 << i), 0, "R2 bit-clear");
      end
    end

    // R1 every primary opcode
    for (int op = 0; op < 64; op++)
      step(0, 1, {6'(op), 5'd9, 5'd3, 16'h0123}, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R1 opcode");

    // R5 displacement extremes and wrap
    step(0, 1, mk(1, 0, 5'd2, 16'h7FFF), 64'h0000_0000_0010_0000, 64'd1, 0, "R5 max-pos");
    step(0, 1, mk(1, 0, 5'd2, 16'h8000), 64'h0000_0000_0010_0000, 64'd1, 0, "R5 max-neg");
    step(0, 1, mk(0, 63, 5'd2, 16'h0001), 64'hFFFF_FFFF_FFFF_FFF8, 64'd0, 0, "R5 wrap");
    step(0, 1, mk(0, 40, 5'd2, 16'hFFFF), 64'h0, 64'd0, 0, "R5 below-zero");

    // R6 branch in delay slot, both when condition true and false
    step(0, 1, mk(1, 10, 5'd4, 16'h0020), 64'h3000, 64'd1 << 10, 1, "R6 slot-true");
    step(0, 1, mk(0, 10, 5'd4, 16'h0020), 64'h3000, 64'd1 << 10, 1, "R6 slot-false");
    // R6 delay slot flag on a foreign word has no effect
    step(0, 1, 32'h0000_0000, 64'h3000, 64'd0, 1, "R6 slot-foreign");

    // R7 not taken still marks the slot
    step(0, 1, mk(1, 33, 5'd6, 16'h0002), 64'h5000, 64'd0, 0, "R7 not-taken");

    // R8 hold while valid low, with changing inputs
    step(0, 1, mk(1, 50, 5'd7, 16'h0040), 64'h6000, 64'd1 << 50, 0, "R8 load");
    step(0, 0, 32'h0000_0000, 64'h0, 64'd0, 0, "R8 idle-a");
    step(0, 0, mk(0, 50, 5'd8, 16'h8000), 64'h9999, 64'd1 << 50, 1, "R8 idle-b");

    // R9 reset after activity
    step(1, 1, mk(1, 1, 5'd1, 16'h0001), 64'h10, 64'd2, 0, "R9 mid-reset");
    step(0, 1, mk(1, 1, 5'd1, 16'h0001), 64'h10, 64'd2, 0, "R9 after-reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule